// File: doc/BRIEF.md
# Transmit DMA Run-State Controller

This block sequences the transmit side of a descriptor-based DMA engine. Software drives a level start bit and a list base address. The controller walks a ring of transmit descriptors and asks a descriptor fetch interface for one descriptor at a time. For each descriptor the DMA owns, it issues one transmit command to the data path. It then waits for the data path to report the end of that frame before it fetches the next descriptor.

The controller reports one of three run states: Stopped, Running or Suspended. When it reaches a descriptor the DMA does not own, it suspends and raises a sticky buffer-unavailable flag. A poll-demand pulse makes it retry the same descriptor. Clearing the start bit is honoured only between frames or while suspended. The next descriptor position survives a stop, so a restart continues where the ring was left. Only the first start after reset loads the list base address.

Descriptors are a fixed 16 bytes apart. An owned descriptor that carries the end-of-ring flag sends the pointer back to the base address.

Top module: `txDmaRunCtrl`

## Requirements
- R1: After reset, runState is 0 (encoding: 0 Stopped, 1 Running, 2 Suspended), and fetchReq, txCmd and bufUnavail are all 0.
- R2: While Stopped with startBit high, the next cycle shows runState 1 and fetchReq high. The first start after reset fetches from listBase.
- R3: An acknowledged fetch with fetchOwn high, while startBit is high, raises txCmd in that same cycle. The following fetch address is the previous one plus 16.
- R4: An owned descriptor acknowledged with fetchEndRing high makes the next fetch address equal to listBase.
- R5: An acknowledged fetch with fetchOwn low gives runState 2 and bufUnavail 1 in the next cycle, and leaves the pointer on the same descriptor.
- R6: If startBit goes low while a frame is in progress, runState stays 1 with no fetch until frameDone. The cycle after frameDone shows runState 0.
- R7: In Suspended with no fetch outstanding, a low startBit gives runState 0 in the next cycle.
- R8: A restart after a stop fetches the saved next-descriptor address, even if listBase has changed in between.
- R9: A pollDemand pulse in Suspended fetches the same descriptor again while runState still reads 2. If the descriptor is owned, txCmd is raised and the controller returns to Running. If not, it stays Suspended.
- R10: pollDemand has no effect in the Stopped or Running states.
- R11: bufUnavail stays set until an unavailClr pulse. If a new set and a clear fall in the same cycle, the set wins.
- R12: fetchReq stays high, with fetchAddr unchanged, until fetchAck is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startBit | input | 1 | Level run control: 1 requests Running, 0 requests Stopped |
| listBase | input | ADDR_W | Base address of the descriptor ring |
| pollDemand | input | 1 | Pulse asking for a retry of the current descriptor while suspended |
| unavailClr | input | 1 | Write-one-to-clear pulse for bufUnavail |
| fetchReq | output | 1 | Descriptor fetch request, held until acknowledged |
| fetchAddr | output | ADDR_W | Address of the descriptor being fetched |
| fetchAck | input | 1 | Fetch completion; ownership fields are valid in this cycle |
| fetchOwn | input | 1 | Fetched descriptor is owned by the DMA |
| fetchEndRing | input | 1 | Fetched descriptor is the last in the ring |
| txCmd | output | 1 | One-cycle command to transmit the fetched frame |
| frameDone | input | 1 | Data path finished the current frame |
| runState | output | 2 | 0 Stopped, 1 Running, 2 Suspended |
| bufUnavail | output | 1 | Sticky transmit-buffer-unavailable flag |

## Verification
Directed sequences cover several cases that each isolate one behaviour. A linear walk separates the +16 step from the end-of-ring wrap. A stop issued mid-frame separates a deferred stop from an immediate one. A restart after listBase has been rewritten separates a resumed pointer from a reloaded base. Repeated polls against unowned and then owned descriptors separate staying suspended from resuming.

Random runs mix ownership, ring wraps, acknowledge latency and frame length. A bench-side expected pointer is compared against every fetch address and every txCmd, so a wrong step, a lost save or a missed wrap shows up as a wrong address.

// File: rtl/txDmaPkg.sv
package txDmaPkg;

  typedef enum logic [1:0] {
    RUN_STOPPED   = 2'd0,
    RUN_RUNNING   = 2'd1,
    RUN_SUSPENDED = 2'd2
  } runStateE;

  typedef enum logic [2:0] {
    C_STOP  = 3'd0,
    C_FETCH = 3'd1,
    C_SEND  = 3'd2,
    C_SUSP  = 3'd3,
    C_POLL  = 3'd4
  } ctrlStateE;

  typedef struct packed {
    logic loadBase;
    logic advance;
    logic setUnavail;
  } ptrStrobeT;

endpackage

// File: rtl/txDmaCtrl.sv
module txDmaCtrl
  import txDmaPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startBit,
  input  logic      pollDemand,
  input  logic      fetchAck,
  input  logic      fetchOwn,
  input  logic      frameDone,
  output ptrStrobeT strobe,
  output logic      fetchReq,
  output logic      txCmd,
  output logic [1:0] runState
);

  ctrlStateE state, nextState;
  logic everStarted;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= C_STOP;
      everStarted <= 1'b0;
    end else begin
      state <= nextState;
      if (state == C_STOP && startBit) everStarted <= 1'b1;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    fetchReq  = 1'b0;
    txCmd     = 1'b0;
    unique case (state)
      C_STOP: begin
        if (startBit) begin
          nextState       = C_FETCH;
          strobe.loadBase = !everStarted;
        end
      end
      C_FETCH, C_POLL: begin
        fetchReq = 1'b1;
        if (fetchAck) begin
          if (!fetchOwn) begin
            strobe.setUnavail = 1'b1;
            nextState         = C_SUSP;
          end else if (!startBit) begin
            nextState = C_STOP;
          end else begin
            txCmd          = 1'b1;
            strobe.advance = 1'b1;
            nextState      = C_SEND;
          end
        end
      end
      C_SEND: begin
        if (frameDone) nextState = startBit ? C_FETCH : C_STOP;
      end
      C_SUSP: begin
        if (!startBit)       nextState = C_STOP;
        else if (pollDemand) nextState = C_POLL;
      end
      default: nextState = C_STOP;
    endcase
  end

  always_comb begin
    unique case (state)
      C_FETCH, C_SEND: runState = RUN_RUNNING;
      C_SUSP, C_POLL:  runState = RUN_SUSPENDED;
      default:         runState = RUN_STOPPED;
    endcase
  end

endmodule

// File: rtl/txDmaPtr.sv
module txDmaPtr
  import txDmaPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ptrStrobeT         strobe,
  input  logic [ADDR_W-1:0] listBase,
  input  logic              fetchEndRing,
  input  logic              unavailClr,
  output logic [ADDR_W-1:0] curPtr,
  output logic              bufUnavail
);

  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] nextPtr;

  always_comb begin
    nextPtr = curPtr;
    if (strobe.loadBase)     nextPtr = listBase;
    else if (strobe.advance) nextPtr = fetchEndRing ? listBase : curPtr + STRIDE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPtr     <= '0;
      bufUnavail <= 1'b0;
    end else begin
      curPtr <= nextPtr;
      if (strobe.setUnavail) bufUnavail <= 1'b1;
      else if (unavailClr)   bufUnavail <= 1'b0;
    end
  end

endmodule

// File: rtl/txDmaRunCtrl.sv
module txDmaRunCtrl
  import txDmaPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startBit,
  input  logic [ADDR_W-1:0] listBase,
  input  logic              pollDemand,
  input  logic              unavailClr,
  output logic              fetchReq,
  output logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchAck,
  input  logic              fetchOwn,
  input  logic              fetchEndRing,
  output logic              txCmd,
  input  logic              frameDone,
  output logic [1:0]        runState,
  output logic              bufUnavail
);

  ptrStrobeT strobe;

  txDmaCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startBit   (startBit),
    .pollDemand (pollDemand),
    .fetchAck   (fetchAck),
    .fetchOwn   (fetchOwn),
    .frameDone  (frameDone),
    .strobe     (strobe),
    .fetchReq   (fetchReq),
    .txCmd      (txCmd),
    .runState   (runState)
  );

  txDmaPtr #(
    .ADDR_W     (ADDR_W),
    .DESC_BYTES (DESC_BYTES)
  ) uPtr (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .listBase     (listBase),
    .fetchEndRing (fetchEndRing),
    .unavailClr   (unavailClr),
    .curPtr       (fetchAddr),
    .bufUnavail   (bufUnavail)
  );

endmodule

// File: rtl/txDmaRunCtrlChk.sv
module txDmaRunCtrlChk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startBit,
  input logic              pollDemand,
  input logic              unavailClr,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchAck,
  input logic              fetchOwn,
  input logic              txCmd,
  input logic              frameDone,
  input logic [1:0]        runState,
  input logic              bufUnavail
);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN) runState != 2'd3); // R1
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (runState == 2'd0 && startBit) |=> (runState == 2'd1 && fetchReq)); // R2
  AST_CMD_NEEDS_OWN: assert property (@(posedge clk) disable iff (!rstN)
    txCmd |-> (fetchReq && fetchAck && fetchOwn && startBit)); // R3
  AST_UNOWNED_SUSPEND: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchAck && !fetchOwn) |=> (runState == 2'd2 && bufUnavail)); // R5
  AST_STOP_DEFERRED: assert property (@(posedge clk) disable iff (!rstN)
    (runState == 2'd1 && !fetchReq && !frameDone) |=> (runState == 2'd1)); // R6
  AST_SUSP_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (runState == 2'd2 && !fetchReq && !startBit) |=> (runState == 2'd0)); // R7
  AST_POLL_IGNORED_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (runState == 2'd0 && !startBit && pollDemand) |=> (runState == 2'd0 && !fetchReq)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (bufUnavail && !unavailClr) |=> bufUnavail); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !fetchAck) |=> (fetchReq && $stable(fetchAddr))); // R12

endmodule

bind txDmaRunCtrl txDmaRunCtrlChk #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startBit   (startBit),
  .pollDemand (pollDemand),
  .unavailClr (unavailClr),
  .fetchReq   (fetchReq),
  .fetchAddr  (fetchAddr),
  .fetchAck   (fetchAck),
  .fetchOwn   (fetchOwn),
  .txCmd      (txCmd),
  .frameDone  (frameDone),
  .runState   (runState),
  .bufUnavail (bufUnavail)
);

// File: tb/sim_txDmaRunCtrl.sv
`timescale 1ns/1ps
module sim_txDmaRunCtrl;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startBit = 1'b0;
  logic [AW-1:0] listBase = 32'h1000;
  logic          pollDemand = 1'b0;
  logic          unavailClr = 1'b0;
  logic          fetchReq;
  logic [AW-1:0] fetchAddr;
  logic          fetchAck = 1'b0;
  logic          fetchOwn = 1'b0;
  logic          fetchEndRing = 1'b0;
  logic          txCmd;
  logic          frameDone = 1'b0;
  logic [1:0]    runState;
  logic          bufUnavail;

  int errCnt = 0;
  int chkCnt = 0;
  logic [AW-1:0] expPtr;

  always #10 clk = ~clk;

  txDmaRunCtrl #(.ADDR_W(AW), .DESC_BYTES(16)) u0 (
    .clk(clk), .rstN(rstN), .startBit(startBit), .listBase(listBase),
    .pollDemand(pollDemand), .unavailClr(unavailClr), .fetchReq(fetchReq),
    .fetchAddr(fetchAddr), .fetchAck(fetchAck), .fetchOwn(fetchOwn),
    .fetchEndRing(fetchEndRing), .txCmd(txCmd), .frameDone(frameDone),
    .runState(runState), .bufUnavail(bufUnavail)
  );

  function automatic logic [AW-1:0] nextDesc(logic [AW-1:0] cur, logic ring, logic [AW-1:0] base);
    return ring ? base : cur + 32'd16;
  endfunction

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog: actual=hung expected=finished");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) tick();
    rstN = 1'b1;
    tick(); settle();
    // R1 reset state
    chk("R1 runState", runState, 0);
    chk("R1 fetchReq", fetchReq, 0);
    chk("R1 txCmd", txCmd, 0);
    chk("R1 bufUnavail", bufUnavail, 0);

    // R2 first start uses listBase
    startBit = 1'b1;
    tick(); settle();
    chk("R2 runState", runState, 1);
    chk("R2 fetchReq", fetchReq, 1);
    chk("R2 fetchAddr", fetchAddr, 32'h1000);
    tick(); settle();
    chk("R12 held req", fetchReq, 1);
    chk("R12 held addr", fetchAddr, 32'h1000);

    // R3 owned descriptor
    fetchAck = 1; fetchOwn = 1; settle();
    chk("R3 txCmd", txCmd, 1);
    tick(); fetchAck = 0; fetchOwn = 0; settle();
    chk("R3 no fetch in frame", fetchReq, 0);
    pollDemand = 1; tick(); pollDemand = 0; settle();
    chk("R10 poll in Running state", runState, 1);
    chk("R10 poll in Running req", fetchReq, 0);
    frameDone = 1; tick(); frameDone = 0; settle();
    chk("R3 step addr", fetchAddr, 32'h1010);
    chk("R3 fetch again", fetchReq, 1);

    // R4 end of ring
    fetchAck = 1; fetchOwn = 1; fetchEndRing = 1;
    tick(); fetchAck = 0; fetchOwn = 0; fetchEndRing = 0;
    frameDone = 1; tick(); frameDone = 0; settle();
    chk("R4 wrap addr", fetchAddr, 32'h1000);

    // R6 deferred stop
    fetchAck = 1; fetchOwn = 1;
    tick(); fetchAck = 0; fetchOwn = 0;
    startBit = 0;
    tick(); tick(); settle();
    chk("R6 still running", runState, 1);
    chk("R6 no fetch", fetchReq, 0);
    frameDone = 1; tick(); frameDone = 0; settle();
    chk("R6 stopped", runState, 0);
    chk("R6 no fetch after stop", fetchReq, 0);

    // R10 poll while stopped
    pollDemand = 1; tick(); pollDemand = 0; settle();
    chk("R10 poll in Stopped state", runState, 0);
    chk("R10 poll in Stopped req", fetchReq, 0);

    // R8 restart resumes saved pointer
    listBase = 32'h2000;
    startBit = 1;
    tick(); settle();
    chk("R8 resume addr", fetchAddr, 32'h1010);
    chk("R2 restart running", runState, 1);

    // R5 unowned
    fetchAck = 1; fetchOwn = 0;
    tick(); fetchAck = 0; settle();
    chk("R5 suspended", runState, 2);
    chk("R5 flag", bufUnavail, 1);
    chk("R5 no fetch", fetchReq, 0);
    tick(); settle();
    chk("R5 stays suspended", runState, 2);

    // R9 poll, still unowned
    pollDemand = 1; tick(); pollDemand = 0; settle();
    chk("R9 refetch req", fetchReq, 1);
    chk("R9 refetch addr", fetchAddr, 32'h1010);
    chk("R9 state during refetch", runState, 2);
    fetchAck = 1; fetchOwn = 0; settle();
    chk("R9 no cmd unowned", txCmd, 0);
    tick(); fetchAck = 0; settle();
    chk("R9 remains suspended", runState, 2);

    // R9 poll, now owned
    pollDemand = 1; tick(); pollDemand = 0;
    fetchAck = 1; fetchOwn = 1; settle();
    chk("R9 cmd owned", txCmd, 1);
    tick(); fetchAck = 0; fetchOwn = 0; settle();
    chk("R9 back running", runState, 1);
    chk("R11 sticky flag", bufUnavail, 1);
    unavailClr = 1; tick(); unavailClr = 0; settle();
    chk("R11 cleared", bufUnavail, 0);

    // R11 set wins over clear
    frameDone = 1; tick(); frameDone = 0; settle();
    chk("R3 next addr", fetchAddr, 32'h1020);
    fetchAck = 1; fetchOwn = 0; unavailClr = 1;
    tick(); fetchAck = 0; unavailClr = 0; settle();
    chk("R11 set wins", bufUnavail, 1);

    // R7 stop while suspended
    startBit = 0;
    tick(); settle();
    chk("R7 stopped", runState, 0);

    // Random phase
    expPtr = 32'h1020;
    startBit = 1;
    tick(); settle();
    chk("R8 resume random", fetchAddr, expPtr);
    for (int i = 0; i < 300; i++) begin
      int lat;
      int gap;
      logic own;
      logic ring;
      if (runState == 2'd2) begin
        if ($urandom_range(0, 1) == 1) begin
          unavailClr = 1; tick(); unavailClr = 0; settle();
          chk("R11 random clear", bufUnavail, 0);
        end
        pollDemand = 1; tick(); pollDemand = 0; settle();
        chk("R9 random refetch", fetchAddr, expPtr);
        chk("R9 random state", runState, 2);
      end
      lat = $urandom_range(0, 3);
      for (int k = 0; k < lat; k++) begin
        tick(); settle();
        chk("R12 random held", fetchReq, 1);
        chk("R12 random addr", fetchAddr, expPtr);
      end
      own  = ($urandom_range(0, 3) != 0);
      ring = ($urandom_range(0, 4) == 0);
      fetchAck = 1; fetchOwn = own; fetchEndRing = ring; settle();
      chk("R3 random cmd", txCmd, own);
      tick(); fetchAck = 0; fetchOwn = 0; fetchEndRing = 0; settle();
      if (own) begin
        expPtr = nextDesc(expPtr, ring, listBase);
        chk("R3 random running", runState, 1);
        gap = $urandom_range(0, 3);
        for (int k = 0; k < gap; k++) tick();
        frameDone = 1; tick(); frameDone = 0; settle();
        chk(ring ? "R4 random wrap" : "R3 random step", fetchAddr, expPtr);
      end else begin
        chk("R5 random suspend", runState, 2);
        chk("R5 random flag", bufUnavail, 1);
      end
    end
    report();
  end

endmodule